// File: doc/BRIEF.md
# Serial Control-Word Loader

This block receives control words over a write-only three-wire serial link (bit clock, data, latch) and stores them in a bank of four 24-bit control registers. Every line is brought into the system clock domain through a two-flop synchronizer. Each rising edge of the serial clock shifts one data bit into a 24-bit shift register, most significant bit first. A rising edge on the latch line copies the whole shift register into the register picked by its lowest bits.

The register-select field has two widths. Three registers are picked by a 2-bit code. The fourth is picked by a 3-bit code whose low two bits match the remaining 2-bit code value. A word whose select field names no register is dropped.

After reset, the host must load registers 3, 2 and 1 and then register 0. Once that has happened, a ready flag rises, and from then on register 0 alone can be rewritten to retune. While the chip-enable input is low, the loading state is cleared and the serial lines are ignored, but the stored words are kept.

Top module: `serial_ctrl_loader`

## Requirements
- R1: On each rising edge of `ser_clk`, the value on `ser_data` is shifted into a 24-bit shift register, most significant bit first, so the last bit sent ends up in bit 0.
- R2: A rising edge on `ser_le` stores the full 24-bit shift-register word, select bits included, into one register. Word bits [1:0]=00 pick `ctrl0`, 01 pick `ctrl1`, and 10 pick `ctrl2`. Word bits [2:0]=011 pick `ctrl3`. No other register changes.
- R3: A word whose bits [2:0] are 111 is discarded, and all four registers keep their values.
- R4: The number of bits shifted between latches is not counted. The word stored is the most recent 24 bits present at the latch edge.
- R5: `cfg_ready` rises when `ctrl0` is written after `ctrl3`, `ctrl2` and `ctrl1` have each been written since reset. It then stays high until reset.
- R6: Writing `ctrl0` before all of `ctrl3`, `ctrl2` and `ctrl1` have been written stores the word but leaves `cfg_ready` low.
- R7: While `chip_en` is low, serial clock and latch edges are ignored, and the registers and `cfg_ready` hold their values. Dropping `chip_en` clears the shift register to zero.
- R8: Synchronous reset clears all four registers, the shift register and `cfg_ready` to zero.
- R9: Once `cfg_ready` is high, each later word with select 00 replaces `ctrl0` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Enable. When low, serial loading stops and the stored words are kept |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le | input | 1 | Latch enable. A rising edge stores the word (asynchronous) |
| ctrl0 | output | 24 | Control register 0 |
| ctrl1 | output | 24 | Control register 1 |
| ctrl2 | output | 24 | Control register 2 |
| ctrl3 | output | 24 | Control register 3 |
| cfg_ready | output | 1 | Power-up load sequence completed |

## Verification
A serial edge reaches the shifter three system clocks after the pin changes: two synchronizer flops, then the edge-detect compare. A latch edge therefore updates its register, and `cfg_ready` when it applies, on the third system clock after `ser_le` rises. The bench holds each serial phase for six clocks and waits six more after the latch falls before it samples, always on the falling clock edge. This leaves every result settled well before it is compared. Expected register images come from a bench-side model that decodes the select bits arithmetically.

// File: rtl/serial_ctrl_pkg.sv
package serial_ctrl_pkg;
    localparam int WORD_W   = 24;
    localparam int NUM_REGS = 4;
    localparam int SYNC_W   = 3;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef enum logic [2:0] {
        TGT_R0   = 3'd0,
        TGT_R1   = 3'd1,
        TGT_R2   = 3'd2,
        TGT_R3   = 3'd3,
        TGT_NONE = 3'd7
    } target_e;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic le;
    } serial_lines_t;

    // Mixed-width select: 2-bit codes for three registers, 3-bit code for the fourth.
    function automatic target_e decode_target(input logic [WORD_W-1:0] w);
        target_e t;
        case (w[1:0])
            2'b00:   t = TGT_R0;
            2'b01:   t = TGT_R1;
            2'b10:   t = TGT_R2;
            default: t = w[2] ? TGT_NONE : TGT_R3;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
    import serial_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  serial_lines_t       lines,
    output logic [WORD_W-1:0]   word,
    output logic                latch
);
    logic sclk_q, le_q;
    logic sclk_rise;

    assign sclk_rise = en & lines.sclk & ~sclk_q;
    assign latch     = en & lines.le & ~le_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
            word   <= '0;
        end else begin
            sclk_q <= lines.sclk;
            le_q   <= lines.le;
            if (!en)
                word <= '0;
            else if (sclk_rise)
                word <= {word[WORD_W-2:0], lines.sdata};
        end
    end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import serial_ctrl_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                latch,
    input  logic [WORD_W-1:0]                   word,
    output logic [NUM_REGS-1:0][WORD_W-1:0]     regs,
    output logic                                ready
);
    target_e           tgt;
    logic [NUM_REGS-1:0] wr;
    logic [NUM_REGS-1:1] seen;

    assign tgt = decode_target(word);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        assign wr[k] = latch && (tgt == target_e'(k));
        always_ff @(posedge clk) begin
            if (rst)
                regs[k] <= '0;
            else if (wr[k])
                regs[k] <= word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= '0;
            ready <= 1'b0;
        end else begin
            seen <= seen | wr[NUM_REGS-1:1];
            if (wr[0] && (&seen))
                ready <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_ctrl_loader.sv
module serial_ctrl_loader
    import serial_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [WORD_W-1:0] ctrl0,
    output logic [WORD_W-1:0] ctrl1,
    output logic [WORD_W-1:0] ctrl2,
    output logic [WORD_W-1:0] ctrl3,
    output logic              cfg_ready
);
    logic [SYNC_W-1:0]                 raw_s;
    serial_lines_t                     lines;
    logic [WORD_W-1:0]                 word;
    logic                              latch;
    logic [NUM_REGS-1:0][WORD_W-1:0]   regs;

    sync_2ff #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_clk, ser_data, ser_le}),
        .q   (raw_s)
    );

    assign lines = serial_lines_t'(raw_s);

    serial_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .en    (chip_en),
        .lines (lines),
        .word  (word),
        .latch (latch)
    );

    ctrl_reg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .latch (latch),
        .word  (word),
        .regs  (regs),
        .ready (cfg_ready)
    );

    assign ctrl0 = regs[0];
    assign ctrl1 = regs[1];
    assign ctrl2 = regs[2];
    assign ctrl3 = regs[3];
endmodule

// File: rtl/serial_ctrl_loader_chk.sv
module serial_ctrl_loader_chk
    import serial_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              chip_en,
    input logic [WORD_W-1:0] ctrl0,
    input logic [WORD_W-1:0] ctrl1,
    input logic [WORD_W-1:0] ctrl2,
    input logic [WORD_W-1:0] ctrl3,
    input logic              cfg_ready
);
    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ctrl0 == '0 && ctrl1 == '0 && ctrl2 == '0 && ctrl3 == '0 && !cfg_ready));

    // R5
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> cfg_ready);

    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> ($stable(ctrl0) && $stable(ctrl1) && $stable(ctrl2)
                      && $stable(ctrl3) && $stable(cfg_ready)));

    // R2
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({!$stable(ctrl0), !$stable(ctrl1), !$stable(ctrl2), !$stable(ctrl3)}) <= 1);

    // R5
    ready_needs_r0_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_ready) |-> (ctrl0[1:0] == 2'b00));
endmodule

bind serial_ctrl_loader serial_ctrl_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chip_en   (chip_en),
    .ctrl0     (ctrl0),
    .ctrl1     (ctrl1),
    .ctrl2     (ctrl2),
    .ctrl3     (ctrl3),
    .cfg_ready (cfg_ready)
);

// File: tb/tb_serial_ctrl_loader.sv
`timescale 1ns/1ps
module tb_serial_ctrl_loader;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_en = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;
    logic [W-1:0] ctrl0, ctrl1, ctrl2, ctrl3;
    logic cfg_ready;

    logic [W-1:0] model [4];
    logic         exp_ready;
    logic [3:1]   exp_seen;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_ctrl_loader dut (
        .clk(clk), .rst(rst), .chip_en(chip_en),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ctrl0(ctrl0), .ctrl1(ctrl1), .ctrl2(ctrl2), .ctrl3(ctrl3),
        .cfg_ready(cfg_ready)
    );

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            ser_clk  = 1'b0;
            wait_clks(6);
            ser_clk  = 1'b1;
            wait_clks(6);
        end
        ser_clk = 1'b0;
        wait_clks(6);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_clks(6);
        ser_le = 1'b0;
        wait_clks(6);
    endtask

    // Bench model: decode select field and apply a stored word.
    task automatic model_store(input logic [W-1:0] w);
        int t;
        case (w[1:0])
            2'b00: t = 0;
            2'b01: t = 1;
            2'b10: t = 2;
            default: t = w[2] ? -1 : 3;
        endcase
        if (t >= 0) begin
            model[t] = w;
            if (t == 0 && exp_seen == 3'b111) exp_ready = 1'b1;
            if (t > 0) exp_seen[t] = 1'b1;
        end
    endtask

    task automatic check(input string req);
        logic [W-1:0] act [4];
        act[0] = ctrl0; act[1] = ctrl1; act[2] = ctrl2; act[3] = ctrl3;
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (act[k] !== model[k]) begin
                errors++;
                $display("FAIL %s ctrl%0d actual %h expected %h", req, k, act[k], model[k]);
            end
        end
        checks++;
        if (cfg_ready !== exp_ready) begin
            errors++;
            $display("FAIL %s cfg_ready actual %b expected %b", req, cfg_ready, exp_ready);
        end
    endtask

    task automatic send_word(input logic [W-1:0] w, input string req);
        shift_bits({40'd0, w}, W);
        pulse_le();
        model_store(w);
        check(req);
    endtask

    function automatic logic [W-1:0] pat(input int i, input logic [2:0] sel, input int selw);
        logic [W-1:0] p;
        p = W'((i * 32'h9E3779) ^ (i << 7) ^ 32'h5A5A5A);
        if (selw == 3) p[2:0] = sel;
        else p[1:0] = sel[1:0];
        return p;
    endfunction

    initial begin
        for (int k = 0; k < 4; k++) model[k] = '0;
        exp_ready = 1'b0;
        exp_seen  = '0;
        wait_clks(4);
        rst = 1'b0;
        wait_clks(2);
        check("R8 reset");

        // R6: register 0 written first does not complete the sequence
        send_word(pat(1, 3'b000, 2), "R6 early r0");

        // R1 R2: sweep 3,2,1 with several patterns
        for (int i = 0; i < 3; i++) send_word(pat(10 + i, 3'b011, 3), "R2 r3 store");
        for (int i = 0; i < 3; i++) send_word(pat(20 + i, 3'b010, 2), "R2 r2 store");
        for (int i = 0; i < 2; i++) send_word(pat(30 + i, 3'b001, 2), "R1 r1 store");
        send_word(24'h800001, "R1 msb first");
        checks++;
        if (cfg_ready !== 1'b0) begin
            errors++;
            $display("FAIL R6 cfg_ready actual %b expected 0", cfg_ready);
        end

        // R5: register 0 completes the sequence
        send_word(pat(40, 3'b000, 2), "R5 ready rise");

        // R3: invalid select 111 discarded
        send_word(pat(50, 3'b111, 3), "R3 invalid discard");
        send_word(24'hFFFFFF, "R3 all ones discard");

        // R4: over-long shift, last 24 bits kept
        begin
            logic [63:0] longv;
            longv = 64'h0000_3F_ABCDEF_12;
            shift_bits(longv, 32);
            pulse_le();
            model_store(longv[W-1:0]);
            check("R4 long word");
        end

        // R7: disabled, edges ignored, state kept, shift register cleared
        chip_en = 1'b0;
        wait_clks(3);
        shift_bits({40'd0, 24'h123450}, W);
        pulse_le();
        check("R7 disabled hold");
        chip_en = 1'b1;
        wait_clks(3);
        shift_bits(64'h155, 10);
        pulse_le();
        model_store(24'h000155);
        check("R7 cleared shifter");

        // R9: single-register retunes after ready
        for (int i = 0; i < 4; i++) send_word(pat(60 + i, 3'b000, 2), "R9 r0 retune");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule